// File: doc/BRIEF.md
# Peripheral Bus Clock Stop Controller

This block decides when the clock of a shared peripheral bus may be halted to save power, and starts it again on demand. It watches four kinds of activity: cycles on the main peripheral bus, cycles on the low-pin-count bus, internal devices that have a cycle waiting for the peripheral bus, and traffic on the serial interrupt line. When all of them have been quiet for a programmable number of clocks, the controller stops driving the shared active-low run-request line and opens a short listening window. Any peripheral that still needs the clock can hold the line low in that window and veto the stop.

If nobody objects, the controller raises the clock-stop control. While the clock is halted, a peripheral that pulls the run-request line low, or any new internal activity, restarts the clock, and the controller drives the line low again until the bus goes idle once more. A global hold input keeps the clock running. The controller itself runs on a free-running 33 MHz clock that the stop control never gates. The open-drain line is modelled as a sampled input plus a drive-low enable. An optional input register stage, chosen by parameter, adds one clock of latency to every reaction to the inputs.

Top module: `busclk_stop_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `clk_stop_o` is 0 and `run_drive_o` is 1.
- R2: While any of `bus_busy_i`, `lpc_busy_i`, `ser_irq_busy_i` or a bit of `dev_req_i` is 1, `clk_stop_o` stays 0 and the idle count restarts from zero.
- R3: `run_drive_o` falls to 0 only after `idle_limit_i`+1 consecutive quiet clock edges with the block driving the line. With a limit of 0 it falls after one quiet edge.
- R4: The listening window lasts 4 clocks. If the run line (`run_line_n_i`, active low) stays high and all sources stay quiet for all 4, `clk_stop_o` rises on the edge that ends the window.
- R5: A low run line seen in any window cycle, including the last one, makes the block drive the line low again for at least 2 clocks. In that case `clk_stop_o` does not rise and the idle count starts over.
- R6: Activity from any source during the window ends it at once. `run_drive_o` returns to 1 and no stop follows.
- R7: While stopped, a low run line clears `clk_stop_o` and sets `run_drive_o` on the next clock edge, which is within 2 clocks.
- R8: While stopped, internal device activity clears `clk_stop_o` and sets `run_drive_o` on the next clock edge.
- R9: While `hold_run_i` is 1, `clk_stop_o` is 0 in the same cycle. From the next edge the line is driven and the idle count is held at zero, whether the block was stopped, in the window or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_run_i | input | 1 | Global hold: keep the bus clock running |
| idle_limit_i | input | IDLE_W | Quiet clocks required, minus one, before the window opens |
| bus_busy_i | input | 1 | Cycle in progress on the peripheral bus |
| lpc_busy_i | input | 1 | Cycle in progress on the low-pin-count bus |
| ser_irq_busy_i | input | 1 | Serial interrupt line activity |
| dev_req_i | input | NUM_DEV | Internal devices with a pending bus cycle |
| run_line_n_i | input | 1 | Sampled level of the shared active-low run-request line |
| run_drive_o | output | 1 | Drive-low enable for the run-request line |
| clk_stop_o | output | 1 | Stop request to the bus clock generator |

## Verification
The bench builds the block with three device request bits, a 4-bit idle limit and the input register stage off, so every reaction lands exactly one edge after its stimulus. Idle limits of 3 and 0 let each window open within a few clocks. The short limit gives many complete entries into and wakes from the stopped state. The zero limit brings within reach the window that opens on the first quiet edge and a veto on the window's final cycle.

// File: rtl/busclk_stop_pkg.sv
package busclk_stop_pkg;

   // Controller phases. RUN and HOLDOFF drive the run line low.
   typedef enum logic [1:0] {
      PH_RUN     = 2'd0,
      PH_LISTEN  = 2'd1,
      PH_HOLDOFF = 2'd2,
      PH_HALTED  = 2'd3
   } stop_phase_e;

endpackage

// File: rtl/busclk_activity_merge.sv
module busclk_activity_merge #(
   parameter int NUM_DEV = 4
) (
   input  logic               bus_busy_i,
   input  logic               lpc_busy_i,
   input  logic               ser_irq_busy_i,
   input  logic [NUM_DEV-1:0] dev_req_i,
   input  logic               run_line_n_i,
   output logic               active_o,
   output logic               line_low_o
);

   logic [NUM_DEV+2:0] src_vec;

   // Gather every source into one vector so that a reduction covers them all.
   genvar g;
   generate
      for (g = 0; g < NUM_DEV; g++) begin : g_dev
         assign src_vec[g] = dev_req_i[g];
      end
   endgenerate

   assign src_vec[NUM_DEV]   = bus_busy_i;
   assign src_vec[NUM_DEV+1] = lpc_busy_i;
   assign src_vec[NUM_DEV+2] = ser_irq_busy_i;

   assign active_o   = |src_vec;
   assign line_low_o = ~run_line_n_i;

endmodule

// File: rtl/busclk_idle_timer.sv
module busclk_idle_timer #(
   parameter int IDLE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic [IDLE_W-1:0] limit_i,
   output logic              expire_o
);

   localparam logic [IDLE_W-1:0] ONE = IDLE_W'(1);

   logic [IDLE_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (cnt_q < limit_i) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign expire_o = !clear_i && (cnt_q >= limit_i);

   // Busy or hold restarts the quiet count (R2, R9)
   assert_count_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_q == '0));

   // A quiet, unexpired cycle advances the count by one (R3)
   assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && !expire_o && $stable(limit_i)) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/busclk_stop_fsm.sv
module busclk_stop_fsm
   import busclk_stop_pkg::*;
#(
   parameter int WIN_LEN  = 4,
   parameter int KEEP_LEN = 2
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        hold_i,
   input  logic        active_i,
   input  logic        line_low_i,
   input  logic        expire_i,
   output stop_phase_e phase_o,
   output logic        drive_o
);

   localparam int PH_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
   localparam logic [PH_W-1:0] WIN_LAST  = PH_W'(WIN_LEN - 1);
   localparam logic [PH_W-1:0] KEEP_LAST = PH_W'(KEEP_LEN - 1);
   localparam logic [PH_W-1:0] PH_ONE    = PH_W'(1);

   stop_phase_e     phase_q, phase_d;
   logic [PH_W-1:0] tick_q, tick_d;
   logic            wake;

   assign wake = hold_i | active_i;

   always_comb begin
      phase_d = phase_q;
      tick_d  = tick_q;
      unique case (phase_q)
         PH_RUN: begin
            if (!hold_i && expire_i) begin
               phase_d = PH_LISTEN;
               tick_d  = '0;
            end
         end
         PH_LISTEN: begin
            if (wake) begin
               phase_d = PH_RUN;
            end else if (line_low_i) begin
               phase_d = PH_HOLDOFF;
               tick_d  = '0;
            end else if (tick_q == WIN_LAST) begin
               phase_d = PH_HALTED;
            end else begin
               tick_d = tick_q + PH_ONE;
            end
         end
         PH_HOLDOFF: begin
            if (hold_i || tick_q == KEEP_LAST) begin
               phase_d = PH_RUN;
            end else begin
               tick_d = tick_q + PH_ONE;
            end
         end
         PH_HALTED: begin
            if (wake || line_low_i) begin
               phase_d = PH_RUN;
            end
         end
         default: phase_d = PH_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_RUN;
         tick_q  <= '0;
      end else begin
         phase_q <= phase_d;
         tick_q  <= tick_d;
      end
   end

   assign phase_o = phase_q;
   assign drive_o = (phase_q == PH_RUN) || (phase_q == PH_HOLDOFF);

   // No stop may follow a cycle with activity (R2)
   assert_busy_blocks_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_i |=> (phase_q != PH_HALTED));

   // The halt is entered only from the final window cycle (R4)
   assert_full_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_HALTED && $past(phase_q) != PH_HALTED)
         |-> ($past(phase_q) == PH_LISTEN && $past(tick_q) == WIN_LAST));

   // A peripheral veto in the window re-drives the line (R5)
   assert_veto_redrive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_LISTEN && line_low_i && !wake) |=> (phase_q == PH_HOLDOFF && drive_o));

   // Window activity returns to running (R6)
   assert_window_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_LISTEN && active_i) |=> (phase_q == PH_RUN));

   // Any wake source leaves the halt on the next edge (R7, R8)
   assert_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_HALTED && (line_low_i || active_i)) |=> (phase_q == PH_RUN && drive_o));

   // Hold forces the running phase from the next edge (R9)
   assert_hold_runs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> (phase_q == PH_RUN));

endmodule

// File: rtl/busclk_stop_ctrl.sv
module busclk_stop_ctrl
   import busclk_stop_pkg::*;
#(
   parameter int NUM_DEV    = 4,
   parameter int IDLE_W     = 8,
   parameter int WIN_LEN    = 4,
   parameter int KEEP_LEN   = 2,
   parameter bit REG_INPUTS = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hold_run_i,
   input  logic [IDLE_W-1:0]  idle_limit_i,
   input  logic               bus_busy_i,
   input  logic               lpc_busy_i,
   input  logic               ser_irq_busy_i,
   input  logic [NUM_DEV-1:0] dev_req_i,
   input  logic               run_line_n_i,
   output logic               run_drive_o,
   output logic               clk_stop_o
);

   // Elaboration-time parameter checks
   generate
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("NUM_DEV must be at least 1");
      end
      if (IDLE_W < 1 || IDLE_W > 32) begin : g_bad_idle
         $error("IDLE_W must lie in 1..32");
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (KEEP_LEN < 1 || KEEP_LEN > WIN_LEN) begin : g_bad_keep
         $error("KEEP_LEN must lie in 1..WIN_LEN");
      end
   endgenerate

   logic        act_raw, low_raw;
   logic        act_use, low_use;
   logic        timer_clear, timer_expire;
   logic        fsm_drive;
   stop_phase_e phase;

   busclk_activity_merge #(
      .NUM_DEV (NUM_DEV)
   ) u_merge (
      .bus_busy_i     (bus_busy_i),
      .lpc_busy_i     (lpc_busy_i),
      .ser_irq_busy_i (ser_irq_busy_i),
      .dev_req_i      (dev_req_i),
      .run_line_n_i   (run_line_n_i),
      .active_o       (act_raw),
      .line_low_o     (low_raw)
   );

   // Optional input stage: trades one clock of reaction time for timing slack.
   generate
      if (REG_INPUTS) begin : g_in_reg
         logic act_q, low_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               act_q <= 1'b1;
               low_q <= 1'b0;
            end else begin
               act_q <= act_raw;
               low_q <= low_raw;
            end
         end
         assign act_use = act_q;
         assign low_use = low_q;
      end else begin : g_in_direct
         assign act_use = act_raw;
         assign low_use = low_raw;
      end
   endgenerate

   assign timer_clear = hold_run_i | act_use | (phase != PH_RUN);

   busclk_idle_timer #(
      .IDLE_W (IDLE_W)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (timer_clear),
      .limit_i  (idle_limit_i),
      .expire_o (timer_expire)
   );

   busclk_stop_fsm #(
      .WIN_LEN  (WIN_LEN),
      .KEEP_LEN (KEEP_LEN)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hold_i     (hold_run_i),
      .active_i   (act_use),
      .line_low_i (low_use),
      .expire_i   (timer_expire),
      .phase_o    (phase),
      .drive_o    (fsm_drive)
   );

   assign run_drive_o = fsm_drive;
   assign clk_stop_o  = (phase == PH_HALTED) & ~hold_run_i;

   // Stop and line drive are never asserted together (R4, R7)
   assert_stop_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_stop_o |-> !run_drive_o);

   // A rising stop is always preceded by a released line (R3)
   assert_release_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_stop_o) |-> !$past(run_drive_o));

endmodule

// File: tb/test_busclk_stop_ctrl.sv
module test_busclk_stop_ctrl;

   localparam int NUM_DEV = 3;
   localparam int IDLE_W  = 4;

   logic               clk = 1'b0;
   logic               rst_ni = 1'b0;
   logic               hold_run_i = 1'b0;
   logic [IDLE_W-1:0]  idle_limit_i = 4'd3;
   logic               bus_busy_i = 1'b0;
   logic               lpc_busy_i = 1'b0;
   logic               ser_irq_busy_i = 1'b0;
   logic [NUM_DEV-1:0] dev_req_i = '0;
   logic               run_line_n_i = 1'b1;
   logic               run_drive_o;
   logic               clk_stop_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   busclk_stop_ctrl #(
      .NUM_DEV    (NUM_DEV),
      .IDLE_W     (IDLE_W),
      .WIN_LEN    (4),
      .KEEP_LEN   (2),
      .REG_INPUTS (1'b0)
   ) i_busclk_stop_ctrl (
      .clk_i          (clk),
      .rst_ni         (rst_ni),
      .hold_run_i     (hold_run_i),
      .idle_limit_i   (idle_limit_i),
      .bus_busy_i     (bus_busy_i),
      .lpc_busy_i     (lpc_busy_i),
      .ser_irq_busy_i (ser_irq_busy_i),
      .dev_req_i      (dev_req_i),
      .run_line_n_i   (run_line_n_i),
      .run_drive_o    (run_drive_o),
      .clk_stop_o     (clk_stop_o)
   );

   typedef struct packed {
      logic       bus;
      logic       lpc;
      logic       ser;
      logic       dev;
      logic       line_n;
      logic       hold;
      logic [3:0] steps;
      logic       exp_stop;
      logic       exp_drive;
      logic [3:0] req;
   } vec_t;

   localparam int NVEC = 29;
   // Idle limit 3: the window opens on the 4th quiet edge, lasts 4 edges.
   localparam vec_t VEC [NVEC] = '{
      '{0,0,0,0,1,0, 3, 0,1, 3},   // R3 not yet released
      '{0,0,0,0,1,0, 1, 0,0, 3},   // R3 window opens
      '{0,0,0,0,1,0, 3, 0,0, 4},   // R4 window cycles
      '{0,0,0,0,1,0, 1, 1,0, 4},   // R4 stop after 4 clocks
      '{0,0,0,0,0,0, 1, 0,1, 7},   // R7 line low wakes
      '{0,0,0,0,1,0, 3, 0,1, 3},   // R3 counting again
      '{1,0,0,0,1,0, 1, 0,1, 2},   // R2 bus cycle restarts count
      '{1,0,0,0,1,0, 8, 0,1, 2},   // R2 long bus activity
      '{0,0,0,0,1,0, 4, 0,0, 3},   // R3 full count after restart
      '{0,0,0,0,0,0, 1, 0,1, 5},   // R5 veto re-drives
      '{0,0,0,0,1,0, 1, 0,1, 5},   // R5 second drive clock
      '{0,0,0,0,1,0, 4, 0,1, 5},   // R5 count restarted
      '{0,0,0,0,1,0, 1, 0,0, 3},   // R3 window again
      '{0,1,0,0,1,0, 1, 0,1, 6},   // R6 low-pin-count cycle aborts
      '{0,0,0,0,1,0, 4, 0,0, 3},   // R3
      '{0,0,1,0,1,0, 1, 0,1, 6},   // R6 serial irq aborts
      '{0,0,0,0,1,0, 4, 0,0, 3},   // R3
      '{0,0,0,0,1,0, 4, 1,0, 4},   // R4 stopped
      '{0,0,0,1,1,0, 1, 0,1, 8},   // R8 device wakes
      '{0,0,0,1,1,0, 6, 0,1, 2},   // R2 device keeps running
      '{0,0,0,0,1,0, 4, 0,0, 3},   // R3
      '{0,0,0,0,1,0, 4, 1,0, 4},   // R4 stopped
      '{0,0,0,0,1,1, 0, 0,0, 9},   // R9 stop drops at once
      '{0,0,0,0,1,1, 1, 0,1, 9},   // R9 drive back
      '{0,0,0,0,1,1,10, 0,1, 9},   // R9 count held
      '{0,0,0,0,1,0, 3, 0,1, 9},   // R9 count from zero
      '{0,0,0,0,1,0, 1, 0,0, 3},   // R3
      '{0,0,0,0,1,1, 1, 0,1, 9},   // R9 hold in window
      '{0,0,0,0,1,0, 4, 0,0, 3}    // R3
   };

   task automatic check(input string req, input logic exp_stop, input logic exp_drive);
      checks++;
      if (clk_stop_o !== exp_stop || run_drive_o !== exp_drive) begin
         fails++;
         $display("FAIL %s: stop=%b drive=%b, expected stop=%b drive=%b",
                  req, clk_stop_o, run_drive_o, exp_stop, exp_drive);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic steps(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
   end

   initial begin
      // R1: reset state
      steps(2);
      #1 check("R1", 1'b0, 1'b1);
      rst_ni = 1'b1;

      // Vector walk
      for (int i = 0; i < NVEC; i++) begin
         bus_busy_i     = VEC[i].bus;
         lpc_busy_i     = VEC[i].lpc;
         ser_irq_busy_i = VEC[i].ser;
         dev_req_i      = {VEC[i].dev, {(NUM_DEV-1){1'b0}}};
         run_line_n_i   = VEC[i].line_n;
         hold_run_i     = VEC[i].hold;
         steps(int'(VEC[i].steps));
         #1 check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].exp_stop, VEC[i].exp_drive);
      end

      // R1: reset in the window forces the reset outputs
      rst_ni = 1'b0;
      #1 check("R1 mid-window reset", 1'b0, 1'b1);
      idle_limit_i = '0;
      steps(1);
      rst_ni = 1'b1;

      // R3: limit zero opens the window on the first quiet edge
      steps(1);
      #1 check("R3 zero limit", 1'b0, 1'b0);
      steps(3);
      #1 check("R4 last window cycle", 1'b0, 1'b0);

      // R5: veto on the last window cycle
      run_line_n_i = 1'b0;
      steps(1);
      #1 check("R5 late veto", 1'b0, 1'b1);
      run_line_n_i = 1'b1;
      steps(1);
      #1 check("R5 late veto second clock", 1'b0, 1'b1);

      report();
   end

endmodule